// File: doc/BRIEF.md
# 8-bit ALU with Zero and Carry Flags

This block is the arithmetic and logic unit of a small accumulator machine. Each operation combines a register operand and a memory operand, selected by a 4-bit operation code, and produces a result at once, along with a write-enable that tells the datapath whether to store that result. A condition register holds two flags, zero (Z) and carry (C), and loads them on the clock edge when the operation-valid strobe is high.

The carry flag is part of every shift and rotate, acting as a ninth bit. Subtract and compare set it as a borrow. A bit-test operation copies the selected bit of the memory operand into it. Set-carry and clear-carry force it directly.

A separate 2-bit condition select asks whether a branch would be taken. The answer is based on the flags already held in the register.

Top module: `alu_zc`

## Requirements
- R1: Operation code 0 (pass) sets the result equal to the memory operand, raises the write-enable and updates Z.
- R2: Every operation with code 0 through 10 loads Z with 1 exactly when its W-bit result is zero. Codes 11 through 15 leave Z unchanged.
- R3: Code 1 (add) gives the result register+memory modulo 2^W. It loads C with the unsigned carry-out.
- R4: Code 2 (subtract) and code 3 (compare) both compute register minus memory modulo 2^W. Both load C with 1 exactly when the unsigned memory operand exceeds the register operand. Compare keeps the write-enable low.
- R5: Codes 4, 5 and 6 give the bitwise AND, OR and XOR of the two operands. They write the result and leave C unchanged.
- R6: Code 7 shifts the register operand left by one and code 8 shifts it right by one. A zero fills the vacated bit, and C receives the bit that leaves the operand.
- R7: Code 9 rotates left through carry: the old C enters bit 0 and bit W-1 becomes the new C. Code 10 rotates right through carry: the old C enters bit W-1 and bit 0 becomes the new C.
- R8: Code 11 sets C to 1 and code 12 clears C to 0. Neither changes Z or raises the write-enable.
- R9: Code 13 (bit test) copies bit `bit_sel` of the memory operand into C. It leaves Z unchanged and raises no write-enable.
- R10: Branch select 0 is taken when Z=1 and select 1 when Z=0. Select 2 (carry clear, also higher-or-same) is taken when C=0. Select 3 (carry set, also lower) is taken when C=1. The decision uses the registered flags only.
- R11: Flags change only on a clock edge with `op_valid` high. Codes 14 and 15 change nothing. With `op_valid` low the write-enable stays low.
- R12: A synchronous reset clears Z and C. For codes 11 to 15 the result shows the register operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | Operation strobe; flags load when high |
| op_sel | input | 4 | Operation code |
| reg_opd | input | W | Register operand |
| mem_opd | input | W | Memory operand |
| bit_sel | input | $clog2(W) | Bit index for bit test |
| br_cond | input | 2 | Branch condition select |
| result | output | W | Operation result |
| wr_en | output | 1 | Result write-enable |
| flag_z | output | 1 | Registered zero flag |
| flag_c | output | 1 | Registered carry flag |
| br_taken | output | 1 | Branch decision from registered flags |

## Verification
The bench builds the block at its default width W=8. At this width the sign-boundary operands 0x7F, 0x80 and 0xFF, and the all-zero results that set Z, can be written directly and reached often by random stimulus. The bench runs chained rotates so that carry must travel between operations. It also sweeps every bit index of the bit test and covers each branch select against all four flag combinations.

// File: rtl/alu_zc.sv
module alu_zc #(
  parameter int W  = 8,
  localparam int BW = (W > 1) ? $clog2(W) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          op_valid,
  input  logic [3:0]    op_sel,
  input  logic [W-1:0]  reg_opd,
  input  logic [W-1:0]  mem_opd,
  input  logic [BW-1:0] bit_sel,
  input  logic [1:0]    br_cond,
  output logic [W-1:0]  result,
  output logic          wr_en,
  output logic          flag_z,
  output logic          flag_c,
  output logic          br_taken
);
  localparam logic [3:0] OP_PASS = 4'd0,  OP_ADD = 4'd1,  OP_SUB = 4'd2,  OP_CMP = 4'd3;
  localparam logic [3:0] OP_AND  = 4'd4,  OP_OR  = 4'd5,  OP_XOR = 4'd6,  OP_LSL = 4'd7;
  localparam logic [3:0] OP_LSR  = 4'd8,  OP_ROL = 4'd9,  OP_ROR = 4'd10, OP_SEC = 4'd11;
  localparam logic [3:0] OP_CLC  = 4'd12, OP_BTST = 4'd13;

  logic [W:0]   sum, diff;
  logic [W-1:0] res;
  logic         c_next, z_upd, wr;

  assign sum  = {1'b0, reg_opd} + {1'b0, mem_opd};
  assign diff = {1'b0, reg_opd} - {1'b0, mem_opd};

  always_comb begin
    res    = reg_opd;
    c_next = flag_c;
    z_upd  = 1'b0;
    wr     = 1'b0;
    unique case (op_sel)
      OP_PASS: begin res = mem_opd; z_upd = 1'b1; wr = 1'b1; end
      OP_ADD:  begin res = sum[W-1:0];  c_next = sum[W];  z_upd = 1'b1; wr = 1'b1; end
      OP_SUB:  begin res = diff[W-1:0]; c_next = diff[W]; z_upd = 1'b1; wr = 1'b1; end
      OP_CMP:  begin res = diff[W-1:0]; c_next = diff[W]; z_upd = 1'b1; end
      OP_AND:  begin res = reg_opd & mem_opd; z_upd = 1'b1; wr = 1'b1; end
      OP_OR:   begin res = reg_opd | mem_opd; z_upd = 1'b1; wr = 1'b1; end
      OP_XOR:  begin res = reg_opd ^ mem_opd; z_upd = 1'b1; wr = 1'b1; end
      OP_LSL:  begin res = {reg_opd[W-2:0], 1'b0};   c_next = reg_opd[W-1]; z_upd = 1'b1; wr = 1'b1; end
      OP_LSR:  begin res = {1'b0, reg_opd[W-1:1]};   c_next = reg_opd[0];   z_upd = 1'b1; wr = 1'b1; end
      OP_ROL:  begin res = {reg_opd[W-2:0], flag_c}; c_next = reg_opd[W-1]; z_upd = 1'b1; wr = 1'b1; end
      OP_ROR:  begin res = {flag_c, reg_opd[W-1:1]}; c_next = reg_opd[0];   z_upd = 1'b1; wr = 1'b1; end
      OP_SEC:  c_next = 1'b1;
      OP_CLC:  c_next = 1'b0;
      OP_BTST: c_next = mem_opd[bit_sel];
      default: ;
    endcase
  end

  assign result = res;
  assign wr_en  = op_valid & wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_z <= 1'b0;
      flag_c <= 1'b0;
    end else if (op_valid) begin
      flag_z <= z_upd ? (res == '0) : flag_z;
      flag_c <= c_next;
    end
  end

  always_comb begin
    unique case (br_cond)
      2'd0: br_taken = flag_z;
      2'd1: br_taken = ~flag_z;
      2'd2: br_taken = ~flag_c;
      default: br_taken = flag_c;
    endcase
  end

  a_r12_reset_clears: assert property (@(posedge clk)
    rst |=> (!flag_z && !flag_c));

  a_r2_zero_tracks_result: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_sel <= OP_ROR) |=> (flag_z == ($past(result) == '0)));

  a_r3_add_carry: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_sel == OP_ADD) |=>
      (flag_c == (($past(result) < $past(reg_opd)) || ($past(result) < $past(mem_opd)))));

  a_r4_cmp_no_write: assert property (@(posedge clk) disable iff (rst)
    (op_sel == OP_CMP) |-> !wr_en);

  a_r8_sec_keeps_z: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_sel == OP_SEC) |=> (flag_c && $stable(flag_z)));

  a_r8_clc_keeps_z: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_sel == OP_CLC) |=> (!flag_c && $stable(flag_z)));

  a_r11_idle_holds: assert property (@(posedge clk) disable iff (rst)
    (!op_valid || op_sel >= 4'd14) |=> ($stable(flag_z) && $stable(flag_c)));

  a_r11_idle_no_write: assert property (@(posedge clk) disable iff (rst)
    !op_valid |-> !wr_en);

  a_r10_eq_branch: assert property (@(posedge clk) disable iff (rst)
    (br_cond == 2'd0) |-> (br_taken == flag_z));
endmodule

// File: tb/alu_zc_tb.sv
`timescale 1ns/100ps
module alu_zc_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       op_valid = 1'b0;
  logic [3:0] op_sel = 4'd0;
  logic [7:0] reg_opd = 8'd0, mem_opd = 8'd0;
  logic [2:0] bit_sel = 3'd0;
  logic [1:0] br_cond = 2'd0;
  logic [7:0] result;
  logic       wr_en, flag_z, flag_c, br_taken;

  int checks = 0, failures = 0;
  bit zm = 1'b0, cm = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  alu_zc #(.W(8)) u_dut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_sel(op_sel),
    .reg_opd(reg_opd), .mem_opd(mem_opd), .bit_sel(bit_sel), .br_cond(br_cond),
    .result(result), .wr_en(wr_en), .flag_z(flag_z), .flag_c(flag_c), .br_taken(br_taken)
  );

  function automatic string req_of(input int op);
    case (op)
      0: return "R1";
      1: return "R3";
      2, 3: return "R4";
      4, 5, 6: return "R5";
      7, 8: return "R6";
      9, 10: return "R7";
      11, 12: return "R8";
      13: return "R9";
      default: return "R11";
    endcase
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step(input bit v, input int op, input int r, input int m,
                      input int b, input int bc, input bit rs);
    int res, ec, wr;
    bit zu, ez;
    @(negedge clk);
    rst = rs; op_valid = v; op_sel = op[3:0]; reg_opd = r[7:0]; mem_opd = m[7:0];
    bit_sel = b[2:0]; br_cond = bc[1:0];
    #1;
    res = r; ec = cm; wr = 0; zu = 0;
    case (op)
      0:  begin res = m; zu = 1; wr = 1; end
      1:  begin res = (r + m) % 256; ec = (r + m > 255); zu = 1; wr = 1; end
      2:  begin res = (r - m + 256) % 256; ec = (m > r); zu = 1; wr = 1; end
      3:  begin res = (r - m + 256) % 256; ec = (m > r); zu = 1; end
      4:  begin res = r & m; zu = 1; wr = 1; end
      5:  begin res = r | m; zu = 1; wr = 1; end
      6:  begin res = r ^ m; zu = 1; wr = 1; end
      7:  begin res = (r * 2) % 256; ec = r / 128; zu = 1; wr = 1; end
      8:  begin res = r / 2; ec = r % 2; zu = 1; wr = 1; end
      9:  begin res = (r * 2) % 256 + cm; ec = r / 128; zu = 1; wr = 1; end
      10: begin res = r / 2 + cm * 128; ec = r % 2; zu = 1; wr = 1; end
      11: ec = 1;
      12: ec = 0;
      13: ec = (m >> b) & 1;
      default: ;
    endcase
    ez = zu ? (res == 0) : zm;
    chk(req_of(op), "result", result, res);
    chk(v ? req_of(op) : "R11", "wr_en", wr_en, v ? wr : 0);
    chk("R2", "flag_z", flag_z, zm);
    chk(req_of(op), "flag_c", flag_c, cm);
    case (bc)
      0: chk("R10", "br_eq", br_taken, zm);
      1: chk("R10", "br_ne", br_taken, !zm);
      2: chk("R10", "br_cc", br_taken, !cm);
      default: chk("R10", "br_cs", br_taken, cm);
    endcase
    if (rs) begin zm = 0; cm = 0; end
    else if (v) begin zm = ez; cm = ec[0]; end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R12: reset state
    step(0, 14, 0, 0, 0, 0, 1);
    step(0, 14, 0, 0, 0, 3, 0);
    // R3 add corners
    step(1, 1, 8'h80, 8'h80, 0, 0, 0);
    step(1, 1, 8'hFF, 8'h01, 0, 0, 0);
    step(1, 1, 8'h7F, 8'h01, 0, 3, 0);
    step(1, 1, 8'hC0, 8'h30, 0, 2, 0);
    // R4 subtract and compare
    step(1, 2, 8'h10, 8'h20, 0, 3, 0);
    step(1, 2, 8'h42, 8'h42, 0, 0, 0);
    step(1, 3, 8'h00, 8'hFF, 0, 1, 0);
    step(1, 3, 8'h55, 8'h55, 0, 2, 0);
    // R1 pass, R5 logic
    step(1, 0, 8'h12, 8'h00, 0, 0, 0);
    step(1, 4, 8'hF0, 8'h0F, 0, 0, 0);
    step(1, 5, 8'hA0, 8'h05, 0, 1, 0);
    step(1, 6, 8'h3C, 8'h3C, 0, 3, 0);
    // R6 shifts, R7 rotate chains
    step(1, 7, 8'h81, 0, 0, 3, 0);
    step(1, 8, 8'h01, 0, 0, 0, 0);
    step(1, 12, 0, 0, 0, 3, 0);
    for (int i = 0; i < 10; i++) step(1, 9, (i == 0) ? 8'hA5 : 8'h5A, 0, 0, 3, 0);
    for (int i = 0; i < 10; i++) step(1, 10, 8'h01 << (i % 8), 0, 0, 2, 0);
    // R8 set/clear carry
    step(1, 0, 8'h00, 8'h00, 0, 0, 0);
    step(1, 11, 8'h33, 0, 0, 0, 0);
    step(1, 12, 8'h33, 0, 0, 3, 0);
    // R9 bit test every index
    for (int b = 0; b < 8; b++) begin
      step(1, 13, 0, 8'hA6, b, 3, 0);
      step(1, 13, 0, 8'h59, b, 2, 0);
    end
    // R11 strobe low and idle codes
    step(1, 11, 0, 0, 0, 3, 0);
    step(0, 12, 0, 0, 0, 3, 0);
    step(0, 1, 8'hFF, 8'hFF, 0, 3, 0);
    step(1, 14, 0, 0, 0, 1, 0);
    step(1, 15, 8'h00, 0, 0, 3, 0);
    // R12 reset mid-run
    step(1, 11, 0, 0, 0, 3, 0);
    step(1, 14, 0, 0, 0, 3, 1);
    step(0, 14, 0, 0, 0, 2, 0);
    // random mix
    for (int i = 0; i < 4000; i++) begin
      int r, m;
      r = $urandom_range(0, 255);
      m = ($urandom_range(0, 7) == 0) ? r : $urandom_range(0, 255);
      step($urandom_range(0, 7) != 0, $urandom_range(0, 15), r, m,
           $urandom_range(0, 7), $urandom_range(0, 3), ($urandom_range(0, 499) == 0));
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule